// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block is the front end of a serially controlled device. A host drives a clock line, a select line and a data line. While the select line is low, each rising edge of the serial clock shifts one bit into the block. When the select line is raised again, the block looks at what it has collected. A frame of the correct length holds a 5-bit command code followed by a 15-bit parameter, and the block issues it as a single-cycle strobe together with the decoded code and parameter.

The three serial inputs are asynchronous to the system clock. The block passes them through a synchronizer chain and finds their edges by oversampling. Three kinds of frame are refused, each with its own one-cycle flag: frames of the wrong length, frames carrying an undefined command code, and a positioned seek whose sector lies beyond the last sector of the array. The code and parameter outputs change only when a command is accepted, so downstream logic can read them at any time after the strobe.

Top module: `cmd_frame_rx`

## Requirements
- R1: After reset, `cmd_valid`, `err_len`, `err_op` and `err_range` are low and `cmd_op` and `cmd_addr` are zero.
- R2: A bit on `spi_sdi` is taken on each rising edge of `spi_sclk` while `spi_cs_n` is low. The first bit received is `cmd_op[4]`, the fifth is `cmd_op[0]`, and the next fifteen are `cmd_addr[14]` down to `cmd_addr[0]`.
- R3: When `spi_cs_n` rises after exactly 20 bits with a defined code (and, for a positioned seek, an in-range address), `cmd_valid` pulses for one cycle with `cmd_op` and `cmd_addr` holding the received fields.
- R4: The defined codes are 00000 (idle), 00001 (identify), 00010 (positioned seek), 00011 (seek from current sector), 00100 (wake and configure), 00110 (halt) and 00111 (halt and sleep). Each of them is accepted.
- R5: When `spi_cs_n` rises after any bit count other than 20 (including zero), `err_len` pulses and `cmd_valid` stays low.
- R6: A 20-bit frame whose code is not in the R4 list (00101, or 01000 through 11111) pulses `err_op` and no command is issued.
- R7: A positioned seek (00010) with an address of 1280 or above pulses `err_range` and is not issued. Address 1279 is accepted. No other code is range-checked, so for example 00011 or 00100 with address 0x7FFF is accepted.
- R8: Rising `spi_sclk` edges while `spi_cs_n` is high are ignored and do not disturb the next frame.
- R9: At most one of the four strobes is high in any cycle, and each lasts exactly one cycle. `cmd_op` and `cmd_addr` change only together with `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, asynchronous |
| spi_cs_n | input | 1 | Active-low frame select, asynchronous |
| spi_sdi | input | 1 | Serial data, most significant bit first |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_op | output | 5 | Code of the last accepted command |
| cmd_addr | output | ADDR_W (15) | Parameter of the last accepted command |
| err_len | output | 1 | One-cycle strobe: the frame had the wrong bit count |
| err_op | output | 1 | One-cycle strobe: the code is undefined |
| err_range | output | 1 | One-cycle strobe: the seek address is beyond the last sector |

## Verification
The bench sends frames of 19, 21 and 0 bits. A design that counted loosely, or kept the most recent 20 bits, would issue a command where a length error is due. The sector boundary is probed at 1279, 1280 and 0x7FFF, and a large parameter is sent on codes whose parameter is don't-care; an off-by-one compare, or a range check applied to every code, would flip one of these outcomes. Clock toggles sent while deselected, and frames that are refused, are each followed by checks that the next frame decodes intact and that the held code and address have not moved. A design that let stray edges or rejected frames leak into its state would fail these checks.

// File: rtl/cfr_pkg.sv
`timescale 1ns/1ps
package cfr_pkg;
   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_IDLE       = 5'b00000,
      OP_IDENT      = 5'b00001,
      OP_SEEK_AT    = 5'b00010,
      OP_SEEK       = 5'b00011,
      OP_WAKE       = 5'b00100,
      OP_HALT       = 5'b00110,
      OP_HALT_SLEEP = 5'b00111
   } cfr_op_e;

   typedef enum logic [1:0] {
      V_OK  = 2'd0,
      V_LEN = 2'd1,
      V_OP  = 2'd2,
      V_RNG = 2'd3
   } cfr_verdict_e;

   function automatic logic op_known(input logic [OP_W-1:0] op);
      case (op)
         OP_IDLE, OP_IDENT, OP_SEEK_AT, OP_SEEK,
         OP_WAKE, OP_HALT, OP_HALT_SLEEP: op_known = 1'b1;
         default:                         op_known = 1'b0;
      endcase
   endfunction

   function automatic logic op_takes_sector(input logic [OP_W-1:0] op);
      op_takes_sector = (op == OP_SEEK_AT);
   endfunction
endpackage

// File: rtl/cfr_sync.sv
`timescale 1ns/1ps
module cfr_sync #(
   parameter int             STAGES  = 2,
   parameter int             WIDTH   = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cfr_shift.sv
`timescale 1ns/1ps
module cfr_shift #(
   parameter int FRAME_W = 20,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               bit_en,
   input  logic               bit_in,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   count
);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(FRAME_W + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame <= '0;
         count <= '0;
      end else begin
         if (start)                       count <= '0;
         else if (bit_en && count != SAT) count <= count + 1'b1;
         if (bit_en) frame <= {frame[FRAME_W-2:0], bit_in};
      end
   end
endmodule

// File: rtl/cfr_judge.sv
`timescale 1ns/1ps
module cfr_judge
   import cfr_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int SECTORS     = 1280,
   parameter bit RANGE_CHECK = 1'b1,
   parameter int CNT_W       = 5,
   localparam int FRAME_W    = OP_W + ADDR_W
) (
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   count,
   output cfr_verdict_e       verdict
);
   logic [OP_W-1:0]   op;
   logic [ADDR_W-1:0] addr;
   logic              beyond;

   assign op   = frame[FRAME_W-1 -: OP_W];
   assign addr = frame[ADDR_W-1:0];

   generate
      if (RANGE_CHECK && (SECTORS < (1 << ADDR_W))) begin : g_range
         localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(SECTORS);
         assign beyond = ({1'b0, addr} >= LIMIT);
      end else begin : g_no_range
         assign beyond = 1'b0;
      end
   endgenerate

   always_comb begin
      if (count != CNT_W'(FRAME_W))                 verdict = V_LEN;
      else if (!op_known(op))                       verdict = V_OP;
      else if (op_takes_sector(op) && beyond)       verdict = V_RNG;
      else                                          verdict = V_OK;
   end
endmodule

// File: rtl/cmd_frame_rx.sv
`timescale 1ns/1ps
module cmd_frame_rx
   import cfr_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int SECTORS     = 1280,
   parameter int SYNC_STAGES = 2,
   parameter bit RANGE_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_sdi,
   output logic              cmd_valid,
   output logic [OP_W-1:0]   cmd_op,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              err_len,
   output logic              err_op,
   output logic              err_range
);
   localparam int FRAME_W = OP_W + ADDR_W;
   localparam int CNT_W   = $clog2(FRAME_W + 2);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cmd_frame_rx: SYNC_STAGES must be at least 2");
      end
      if (SECTORS < 1 || SECTORS > (1 << ADDR_W)) begin : g_bad_sectors
         $error("cmd_frame_rx: SECTORS must lie in 1 .. 2**ADDR_W");
      end
   endgenerate

   logic [2:0]         pins_s;
   logic               cs_s, sclk_s, sdi_s;
   logic               cs_q, sclk_q;
   logic               frame_start, frame_end, bit_take;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   count;
   cfr_verdict_e       verdict;

   cfr_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .d({spi_cs_n, spi_sclk, spi_sdi}), .q(pins_s)
   );
   assign {cs_s, sclk_s, sdi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         cs_q   <= cs_s;
         sclk_q <= sclk_s;
      end
   end

   assign frame_start = cs_q & ~cs_s;
   assign frame_end   = ~cs_q & cs_s;
   assign bit_take    = ~cs_s & sclk_s & ~sclk_q;

   cfr_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .start(frame_start),
      .bit_en(bit_take), .bit_in(sdi_s), .frame(frame), .count(count)
   );

   cfr_judge #(.ADDR_W(ADDR_W), .SECTORS(SECTORS), .RANGE_CHECK(RANGE_CHECK),
               .CNT_W(CNT_W)) i_judge (
      .frame(frame), .count(count), .verdict(verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         err_len   <= 1'b0;
         err_op    <= 1'b0;
         err_range <= 1'b0;
         cmd_op    <= '0;
         cmd_addr  <= '0;
      end else begin
         cmd_valid <= 1'b0;
         err_len   <= 1'b0;
         err_op    <= 1'b0;
         err_range <= 1'b0;
         if (frame_end) begin
            case (verdict)
               V_OK: begin
                  cmd_valid <= 1'b1;
                  cmd_op    <= frame[FRAME_W-1 -: OP_W];
                  cmd_addr  <= frame[ADDR_W-1:0];
               end
               V_LEN:   err_len   <= 1'b1;
               V_OP:    err_op    <= 1'b1;
               default: err_range <= 1'b1;
            endcase
         end
      end
   end
endmodule

// File: rtl/cfr_checker.sv
`timescale 1ns/1ps
module cfr_checker #(
   parameter int ADDR_W  = 15,
   parameter int SECTORS = 1280
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [4:0]        cmd_op,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              err_len,
   input logic              err_op,
   input logic              err_range
);
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(SECTORS);
   logic any_strobe;
   assign any_strobe = cmd_valid | err_len | err_op | err_range;

   p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_valid, err_len, err_op, err_range}));

   p_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      any_strobe |=> !any_strobe);

   p_fields_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> ($stable(cmd_op) && $stable(cmd_addr)));

   p_known_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_op inside {5'b00000, 5'b00001, 5'b00010, 5'b00011,
                                    5'b00100, 5'b00110, 5'b00111}));

   p_sector_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 5'b00010) |-> ({1'b0, cmd_addr} < LIMIT));
endmodule

bind cmd_frame_rx cfr_checker #(.ADDR_W(ADDR_W), .SECTORS(SECTORS)) i_cfr_checker (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_addr(cmd_addr), .err_len(err_len), .err_op(err_op), .err_range(err_range)
);

// File: tb/test_cmd_frame_rx.sv
`timescale 1ns/1ps
module test_cmd_frame_rx;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, sclk, cs_n, sdi;
   logic        cmd_valid, err_len, err_op, err_range;
   logic [4:0]  cmd_op;
   logic [14:0] cmd_addr;

   cmd_frame_rx i_cmd_frame_rx (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .err_len(err_len), .err_op(err_op), .err_range(err_range)
   );

   int n_chk = 0, n_err = 0;
   int c_ok = 0, c_len = 0, c_op = 0, c_rng = 0;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (cmd_valid) c_ok++;
      if (err_len)   c_len++;
      if (err_op)    c_op++;
      if (err_range) c_rng++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] w, input int n);
      c_ok = 0; c_len = 0; c_op = 0; c_rng = 0;
      cs_n = 1'b0;
      repeat (4) @(posedge clk);
      for (int i = n - 1; i >= 0; i--) begin
         sdi = w[i];
         repeat (4) @(posedge clk);
         sclk = 1'b1;
         repeat (4) @(posedge clk);
         sclk = 1'b0;
      end
      repeat (4) @(posedge clk);
      cs_n = 1'b1;
      repeat (12) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic outcome(input string req, input int ok, input int ln, input int op, input int rg);
      chk(c_ok  == ok, {req, " cmd_valid pulses"}, c_ok,  ok);
      chk(c_len == ln, {req, " err_len pulses"},   c_len, ln);
      chk(c_op  == op, {req, " err_op pulses"},    c_op,  op);
      chk(c_rng == rg, {req, " err_range pulses"}, c_rng, rg);
   endtask

   task automatic fields(input string req, input logic [4:0] op, input logic [14:0] ad);
      chk(cmd_op == op,   {req, " cmd_op"},   int'(cmd_op),   int'(op));
      chk(cmd_addr == ad, {req, " cmd_addr"}, int'(cmd_addr), int'(ad));
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(!cmd_valid && !err_len && !err_op && !err_range, "R1 strobes low", 0, 0);
      fields("R1", 5'd0, 15'd0);
   endtask

   task automatic t_basic;
      send({12'd0, 5'b00010, 15'd1234}, 20);
      outcome("R2 R3 seek 1234", 1, 0, 0, 0);
      fields("R2 R3 seek 1234", 5'b00010, 15'd1234);
      send({12'd0, 5'b00100, 15'h5A3}, 20);
      outcome("R3 wake", 1, 0, 0, 0);
      fields("R2 wake bit order", 5'b00100, 15'h5A3);
   endtask

   task automatic t_all_codes;
      logic [4:0] codes [7] = '{5'b00000, 5'b00001, 5'b00010, 5'b00011,
                                5'b00100, 5'b00110, 5'b00111};
      for (int k = 0; k < 7; k++) begin
         send({12'd0, codes[k], 15'(k + 7)}, 20);
         outcome("R4 defined code", 1, 0, 0, 0);
         fields("R4 defined code", codes[k], 15'(k + 7));
      end
   endtask

   task automatic t_bad_code;
      send({12'd0, 5'b00101, 15'd3}, 20);
      outcome("R6 code 00101", 0, 0, 1, 0);
      fields("R6 fields held", 5'b00111, 15'd13);
      send({12'd0, 5'b11111, 15'd3}, 20);
      outcome("R6 code 11111", 0, 0, 1, 0);
   endtask

   task automatic t_length;
      send({13'd0, 5'b00001, 14'd5}, 19);
      outcome("R5 19 bits", 0, 1, 0, 0);
      send({11'd0, 1'b0, 5'b00001, 15'd5}, 21);
      outcome("R5 21 bits", 0, 1, 0, 0);
      send(32'd0, 0);
      outcome("R5 0 bits", 0, 1, 0, 0);
      fields("R9 fields held after errors", 5'b00111, 15'd13);
   endtask

   task automatic t_range;
      send({12'd0, 5'b00010, 15'd1279}, 20);
      outcome("R7 sector 1279", 1, 0, 0, 0);
      fields("R7 sector 1279", 5'b00010, 15'd1279);
      send({12'd0, 5'b00010, 15'd1280}, 20);
      outcome("R7 sector 1280", 0, 0, 0, 1);
      send({12'd0, 5'b00010, 15'h7FFF}, 20);
      outcome("R7 sector 0x7FFF", 0, 0, 0, 1);
      fields("R7 fields held", 5'b00010, 15'd1279);
      send({12'd0, 5'b00011, 15'h7FFF}, 20);
      outcome("R7 seek from current any address", 1, 0, 0, 0);
      fields("R7 seek from current", 5'b00011, 15'h7FFF);
   endtask

   task automatic t_deselected;
      sdi = 1'b1;
      for (int i = 0; i < 5; i++) begin
         repeat (4) @(posedge clk);
         sclk = 1'b1;
         repeat (4) @(posedge clk);
         sclk = 1'b0;
      end
      send({12'd0, 5'b00001, 15'd42}, 20);
      outcome("R8 after idle clocks", 1, 0, 0, 0);
      fields("R8 after idle clocks", 5'b00001, 15'd42);
   endtask

   initial begin
      rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0;
      repeat (5) @(posedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      t_reset();
      t_basic();
      t_all_codes();
      t_bad_code();
      t_length();
      t_range();
      t_deselected();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule